// File: doc/BRIEF.md
# Watchdog-Gated Digital Output Stage

This block drives a bank of digital output pins for a fieldbus slave. A host-side bus writes output data one byte at a time into a staging register. The staged word moves to the pins only on an output event. The event is chosen from three strobes that other parts of the chip supply: end of frame, sync pulse 0 or sync pulse 1. Each byte write also retriggers a process-data watchdog. The watchdog counts down a programmable time on a prescaled tick.

When the watchdog runs out, the pins are forced low. A programmed time of zero turns the watchdog off. The clearing can take effect on the first cycle after expiry or wait for the next output event. A separate strobe-mode input blocks the immediate option. An external output-enable input clears the pins whenever it is low. A one-cycle trigger pulse is given on every retrigger so that an external watchdog can be used. A registered tri-state enable stays off until the configuration-loaded input is high.

Top module: `wd_output_stage`

## Requirements
- R1: A write with `wr_en` high puts `wr_data` into byte lane `wr_addr` of the staging word (lane k is bits 8k+7..8k). The other lanes keep their values. The staged word reaches `dout` only through an output event.
- R2: `ev_sel` picks the output event: 0 = `eof_pulse`, 1 = `sync0_pulse`, 2 = `sync1_pulse`, 3 = no event. On the clock edge where the selected strobe is high and the watchdog permits output, the staging word (as it was before any write on that same edge) is latched. Pulses on the strobes that are not selected have no effect.
- R3: While `oe_ext` is sampled low, `dout` is 0 on the next cycle. When `oe_ext` goes high again, the latched value reappears.
- R4: `wd_trig` is high for exactly the cycle that follows each cycle with `wr_en` high, and low otherwise.
- R5: With `wd_time` = 0, the watchdog is off and output events latch the staged data without any trigger.
- R6: After reset, with a nonzero `wd_time` and no trigger yet, output events latch 0.
- R7: A trigger reloads the count with `wd_time` and restarts the prescaler. The watchdog stays active for `wd_time`*PRESCALE cycles after the trigger edge and then expires.
- R8: With `wd_immediate` = 1 and `strobe_wd_mode` = 0, the latched value becomes 0 on the first edge at which the watchdog is expired.
- R9: With `wd_immediate` = 0, expiry leaves the latched value unchanged until the next output event, which latches 0.
- R10: With `strobe_wd_mode` = 1, expiry behaves as in R9 whatever `wd_immediate` is.
- R11: A write after expiry re-arms the watchdog, and the next output event drives fresh data again.
- R12: `dout_oe` equals `cfg_loaded` delayed by one cycle. Reset clears `dout`, `dout_oe` and `wd_trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loaded | input | 1 | Configuration loaded; enables the pin drivers |
| wr_en | input | 1 | Byte write strobe; also retriggers the watchdog |
| wr_addr | input | $clog2(NBYTES) | Byte lane select |
| wr_data | input | 8 | Write byte |
| ev_sel | input | 2 | Output event select |
| eof_pulse | input | 1 | End-of-frame strobe |
| sync0_pulse | input | 1 | Sync pulse 0 |
| sync1_pulse | input | 1 | Sync pulse 1 |
| oe_ext | input | 1 | External output enable; low clears the pins |
| wd_time | input | TIME_W | Watchdog time in prescaled ticks; 0 disables |
| wd_immediate | input | 1 | 1 = clear at once on expiry, 0 = clear at next event |
| strobe_wd_mode | input | 1 | Valid strobe shows triggers; forces delayed clearing |
| dout | output | NBYTES*8 | Output pin values |
| dout_oe | output | 1 | Tri-state enable for the pins |
| wd_trig | output | 1 | One-cycle watchdog trigger pulse |

## Verification
Every result of this block is registered once. `dout`, `dout_oe` and `wd_trig` all change on the first clock edge after the stimulus: a selected strobe, an `oe_ext` level, a `cfg_loaded` level or a write. Watchdog expiry comes `wd_time`*PRESCALE cycles after the trigger edge, and an immediate clear is visible one cycle after that. The bench keeps a behavioural model that advances on the same edge as the design. It compares all three outputs on the falling edge, when each result is already due and the inputs for the next edge are not yet applied. Expiry is tested by waiting past the expiry cycle with no events, then applying one event.

// File: rtl/wdo_pkg.sv
package wdo_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    EV_FRAME_END = 2'd0,
    EV_SYNC_A    = 2'd1,
    EV_SYNC_B    = 2'd2,
    EV_OFF       = 2'd3
  } ev_src_e;
endpackage

// File: rtl/wdo_watchdog.sv
module wdo_watchdog #(
  parameter int TIME_W   = 16,
  parameter int PRESCALE = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [TIME_W-1:0] wd_time,
  output logic              wd_ok,
  output logic              kick_pulse
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic              active_q;
  logic [TIME_W-1:0] cnt_q;
  logic [PRE_W-1:0]  pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      pre_q      <= '0;
      kick_pulse <= 1'b0;
    end else begin
      kick_pulse <= kick;
      if (kick) begin
        active_q <= 1'b1;
        cnt_q    <= wd_time;
        pre_q    <= '0;
      end else if (active_q) begin
        if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q <= TIME_W'(1)) active_q <= 1'b0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign wd_ok = (wd_time == '0) || active_q;
endmodule

// File: rtl/wdo_evt_sel.sv
module wdo_evt_sel
  import wdo_pkg::*;
(
  input  ev_src_e sel,
  input  logic    frame_end,
  input  logic    sync_a,
  input  logic    sync_b,
  output logic    fire
);
  always_comb begin
    unique case (sel)
      EV_FRAME_END: fire = frame_end;
      EV_SYNC_A:    fire = sync_a;
      EV_SYNC_B:    fire = sync_b;
      default:      fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdo_lanes.sv
module wdo_lanes
  import wdo_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [LANE_W-1:0]        wr_data,
  output logic [NBYTES*LANE_W-1:0] stage
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                                  lane_q <= '0;
      else if (wr_en && (wr_addr == AW'(g)))    lane_q <= wr_data;
    end
    assign stage[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/wd_output_stage.sv
module wd_output_stage
  import wdo_pkg::*;
#(
  parameter int NBYTES   = 4,
  parameter int TIME_W   = 16,
  parameter int PRESCALE = 1000,
  localparam int DW = NBYTES * LANE_W,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_loaded,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        ev_sel,
  input  logic              eof_pulse,
  input  logic              sync0_pulse,
  input  logic              sync1_pulse,
  input  logic              oe_ext,
  input  logic [TIME_W-1:0] wd_time,
  input  logic              wd_immediate,
  input  logic              strobe_wd_mode,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  output logic              wd_trig
);
  logic [DW-1:0] stage;
  logic [DW-1:0] lat_q, lat_d;
  logic          wd_ok, fire, imm_en;

  wdo_lanes #(.NBYTES(NBYTES)) u_lanes (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stage(stage)
  );

  wdo_watchdog #(.TIME_W(TIME_W), .PRESCALE(PRESCALE)) u_wd (
    .clk(clk), .rst(rst), .kick(wr_en), .wd_time(wd_time),
    .wd_ok(wd_ok), .kick_pulse(wd_trig)
  );

  wdo_evt_sel u_evt (
    .sel(ev_src_e'(ev_sel)), .frame_end(eof_pulse),
    .sync_a(sync0_pulse), .sync_b(sync1_pulse), .fire(fire)
  );

  assign imm_en = wd_immediate && !strobe_wd_mode;

  always_comb begin
    lat_d = lat_q;
    if (fire)                 lat_d = wd_ok ? stage : '0;
    else if (imm_en && !wd_ok) lat_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      lat_q   <= lat_d;
      dout    <= oe_ext ? lat_d : '0;
      dout_oe <= cfg_loaded;
    end
  end
endmodule

// File: rtl/wdo_checker.sv
module wdo_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          oe_ext,
  input logic          cfg_loaded,
  input logic          wd_ok,
  input logic          imm_en,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          wd_trig
);
  // R4
  trig_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wd_trig);
  // R4
  trig_only_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wd_trig);
  // R3
  oe_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_ext |=> (dout == '0));
  // R12
  drv_en_follows_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_loaded |=> dout_oe);
  // R12
  drv_en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_loaded |=> !dout_oe);
  // R8
  immediate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_en && !wd_ok) |=> (dout == '0));
endmodule

bind wd_output_stage wdo_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .oe_ext(oe_ext),
  .cfg_loaded(cfg_loaded), .wd_ok(wd_ok), .imm_en(imm_en),
  .dout(dout), .dout_oe(dout_oe), .wd_trig(wd_trig)
);

// File: tb/wd_output_stage_tb.sv
`timescale 1ns/1ps
module wd_output_stage_tb;
  localparam int P = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_loaded = 0, wr_en = 0, eof_pulse = 0, sync0_pulse = 0, sync1_pulse = 0;
  logic        oe_ext = 1, wd_immediate = 0, strobe_wd_mode = 0;
  logic [1:0]  wr_addr = 0, ev_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] wd_time = 0;
  logic [31:0] dout;
  logic        dout_oe, wd_trig;

  int    checks = 0, failures = 0;
  bit    chk_on = 0, done = 0;
  string cur_req = "R12";

  always #2.5 clk = ~clk;

  wd_output_stage #(.NBYTES(4), .TIME_W(16), .PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .cfg_loaded(cfg_loaded), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ev_sel(ev_sel),
    .eof_pulse(eof_pulse), .sync0_pulse(sync0_pulse), .sync1_pulse(sync1_pulse),
    .oe_ext(oe_ext), .wd_time(wd_time), .wd_immediate(wd_immediate),
    .strobe_wd_mode(strobe_wd_mode), .dout(dout), .dout_oe(dout_oe), .wd_trig(wd_trig)
  );

  // behavioural reference
  logic [31:0] m_stage, m_lat, m_dout;
  logic        m_oe, m_trig, m_active;
  int          m_cnt, m_pre;

  always @(posedge clk) begin : model
    bit ok, ev;
    logic [31:0] nl;
    if (rst) begin
      m_stage = 0; m_lat = 0; m_dout = 0; m_oe = 0; m_trig = 0;
      m_active = 0; m_cnt = 0; m_pre = 0;
    end else begin
      ok = (wd_time == 0) || m_active;
      ev = (ev_sel == 0 && eof_pulse) || (ev_sel == 1 && sync0_pulse) ||
           (ev_sel == 2 && sync1_pulse);
      nl = m_lat;
      if (ev) nl = ok ? m_stage : 32'h0;
      else if (wd_immediate && !strobe_wd_mode && !ok) nl = 32'h0;
      m_lat  = nl;
      m_dout = oe_ext ? nl : 32'h0;
      m_oe   = cfg_loaded;
      m_trig = wr_en;
      if (wr_en) begin
        m_active = 1; m_cnt = wd_time; m_pre = 0;
      end else if (m_active) begin
        if (m_pre == P - 1) begin
          m_pre = 0;
          if (m_cnt <= 1) m_active = 0;
          m_cnt = m_cnt - 1;
        end else m_pre = m_pre + 1;
      end
      if (wr_en) m_stage[8*wr_addr +: 8] = wr_data;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("dout", dout, m_dout);
      chk("dout_oe", {31'h0, dout_oe}, {31'h0, m_oe});
      chk("wd_trig", {31'h0, wd_trig}, {31'h0, m_trig});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    eof_pulse = (which == 0); sync0_pulse = (which == 1); sync1_pulse = (which == 2);
    @(negedge clk);
    eof_pulse = 0; sync0_pulse = 0; sync1_pulse = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1;
    cur_req = "R12"; idle(1); rst = 0; idle(2);
    cfg_loaded = 1; idle(3);
    // R1 R5: watchdog off, bytes written then latched by end of frame
    cur_req = "R1"; wd_time = 0; ev_sel = 0;
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44); idle(2);
    cur_req = "R5"; pulse(0); idle(2);
    // R2: select each source, unselected strobes ignored
    cur_req = "R2"; wr(0, 8'hAA); ev_sel = 1; pulse(0); pulse(2); idle(1);
    pulse(1); idle(1);
    wr(2, 8'h5C); ev_sel = 2; pulse(1); pulse(2); idle(1);
    wr(3, 8'hE7); ev_sel = 3; pulse(0); pulse(1); pulse(2); idle(2);
    // R3: external enable
    cur_req = "R3"; oe_ext = 0; idle(4); oe_ext = 1; idle(2);
    // R6: fresh reset with watchdog enabled, no trigger
    cur_req = "R6"; rst = 1; idle(2); wd_time = 5; rst = 0; ev_sel = 0; idle(1);
    pulse(0); idle(2);
    // R4 R7: trigger and countdown
    cur_req = "R4"; wr(1, 8'h3C); idle(1);
    cur_req = "R7"; pulse(0); idle(5 * P + 4); pulse(0); idle(2);
    // R8: immediate clear
    cur_req = "R8"; wd_immediate = 1; wr(0, 8'h99); pulse(0); idle(5 * P + 4);
    // R11: re-arm
    cur_req = "R11"; wr(2, 8'h77); pulse(0); idle(3);
    // R9: delayed clear
    cur_req = "R9"; wd_immediate = 0; idle(5 * P + 4); pulse(0); idle(2);
    // R10: strobe mode forces delayed clear
    cur_req = "R10"; wd_immediate = 1; strobe_wd_mode = 1; wr(3, 8'h12); pulse(0);
    idle(5 * P + 4); pulse(0); idle(2);
    cur_req = "R12"; cfg_loaded = 0; idle(3);
    done = 1;
    summary();
  end
endmodule